// File: doc/BRIEF.md
# USB Endpoint Handshake Controller

This block holds the per-endpoint control state of a USB device controller and picks the handshake that answers each transaction. It also tracks the DATA0/DATA1 toggle that the endpoint expects next. Software works it through paired set and clear strobes for three controls: a stall request, a toggle reset and a NYET-suppress option. The packet engine gives it one-cycle pulses for three token events (SETUP packet, OUT data packet, IN token) and for an ACK received from the host. It also gives it a count of free buffer banks.

The chosen handshake is registered and appears one cycle after the token pulse, together with a valid strobe. The expected toggle is brought out continuously, so the packet engine can label outgoing data or check incoming data. The stall and NYET-suppress bits are also visible at the ports.

Only one event is acted on per cycle. The priority is SETUP, then OUT, then IN, then host ACK.

Top module: `usb_ep_hs_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `hs_valid`, `stall_q`, `nyet_dis_q` and `exp_toggle` are all 0.
- R2: A pulse on `sw_stall_set` sets `stall_q` from the next cycle on, and a pulse on `sw_stall_clr` clears it. When both strobes come in the same cycle, the set wins.
- R3: A `tok_setup` pulse is answered with ACK even while stalled. It clears `stall_q` unless `sw_stall_set` is high in the same cycle. It sets `exp_toggle` to 1 (DATA1).
- R4: While `stall_q` is 1, an OUT or IN event is answered with STALL and `exp_toggle` is unchanged.
- R5: When the endpoint is not stalled and `free_banks` is 0, an OUT or IN event is answered with NAK and `exp_toggle` is unchanged.
- R6: In high-speed mode (`hs_mode`=1), an OUT event with `free_banks`=1 while `nyet_dis_q`=0 is answered with NYET. The packet counts as accepted and the toggle flips.
- R7: `sw_nyet_dis_set` and `sw_nyet_dis_clr` set and clear `nyet_dis_q`, and the set wins when both come together. While `nyet_dis_q` is 1, the case of R6 is answered with ACK.
- R8: With `hs_mode`=0, an accepted OUT event (not stalled, `free_banks`>0) is always answered with ACK and never with NYET. The toggle flips.
- R9: An IN event with data ready (not stalled, `free_banks`>0) gives code DATA and leaves the toggle alone. A `host_ack` pulse in a cycle with no token flips `exp_toggle`.
- R10: A `sw_tgl_rst` pulse makes `exp_toggle` 0 in the next cycle and overrides any flip in that cycle. A SETUP in the same cycle overrides it, giving 1.
- R11: `hs_valid` is high for exactly the one cycle after each token event (SETUP, OUT or IN) and low otherwise, including after `host_ack` alone. `hs_code` uses NONE=0, ACK=1, NAK=2, STALL=3, NYET=4, DATA=5. It is NONE whenever `hs_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_stall_set | input | 1 | Software strobe: request stall |
| sw_stall_clr | input | 1 | Software strobe: release stall |
| sw_tgl_rst | input | 1 | Software strobe: reset toggle to DATA0 |
| sw_nyet_dis_set | input | 1 | Software strobe: replace NYET with ACK |
| sw_nyet_dis_clr | input | 1 | Software strobe: restore NYET |
| hs_mode | input | 1 | 1 = high-speed link, 0 = full-speed |
| tok_setup | input | 1 | SETUP packet received pulse |
| tok_out | input | 1 | OUT data packet received pulse |
| tok_in | input | 1 | IN token received pulse |
| host_ack | input | 1 | ACK from host after IN data pulse |
| free_banks | input | BANK_W | Free (OUT) or ready (IN) buffer banks |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 3 | Handshake code |
| exp_toggle | output | 1 | Expected data toggle (0=DATA0) |
| stall_q | output | 1 | Stall request bit |
| nyet_dis_q | output | 1 | NYET-suppress bit |

## Verification
Every result is due exactly one clock edge after the stimulus that causes it. This holds for the handshake code with its valid strobe, the toggle, and both control bits. The bench drives each input set on the falling edge. It samples all outputs shortly after the next rising edge and compares them with a model that steps once per cycle. No result is looked for at any other time. A reference model in the bench turns each cycle's inputs and the previous expected state into the expected next outputs. Directed sequences place strobe collisions and SETUP-during-stall in single cycles; random traffic covers the rest.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  typedef enum logic [2:0] {
    HS_NONE  = 3'd0,
    HS_ACK   = 3'd1,
    HS_NAK   = 3'd2,
    HS_STALL = 3'd3,
    HS_NYET  = 3'd4,
    HS_DATA  = 3'd5
  } hs_code_t;

  localparam int CTRL_BITS = 2;
  localparam int BIT_STALL = 0;
  localparam int BIT_NYDIS = 1;
endpackage

// File: rtl/usb_ep_ctrl_bits.sv
module usb_ep_ctrl_bits #(
  parameter int NBITS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] set_i,
  input  logic [NBITS-1:0] clr_i,
  output logic [NBITS-1:0] bits_q
);
  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    logic nxt;
    logic en;
    always_comb begin
      en  = set_i[i] | clr_i[i];
      nxt = set_i[i];  // set wins over clear
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  bits_q[i] <= 1'b0;
      else if (en) bits_q[i] <= nxt;
    end
  end
endmodule

// File: rtl/usb_ep_hs_sel.sv
module usb_ep_hs_sel
  import usb_ep_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              stall,
  input  logic              nyet_dis,
  input  logic              hs_mode,
  input  logic [BANK_W-1:0] free_banks,
  input  logic              tok_setup,
  input  logic              tok_out,
  input  logic              tok_in,
  input  logic              host_ack,
  output hs_code_t          code,
  output logic              any_tok,
  output logic              flip
);
  localparam logic [BANK_W-1:0] ONE_BANK = BANK_W'(1);

  logic no_space;
  logic last_bank;

  always_comb begin
    no_space  = (free_banks == '0);
    last_bank = (free_banks == ONE_BANK);
    any_tok   = tok_setup | tok_out | tok_in;
    code      = HS_NONE;
    flip      = 1'b0;
    if (tok_setup) begin
      code = HS_ACK;
    end else if (tok_out) begin
      if (stall)         code = HS_STALL;
      else if (no_space) code = HS_NAK;
      else begin
        flip = 1'b1;
        if (hs_mode && last_bank && !nyet_dis) code = HS_NYET;
        else                                   code = HS_ACK;
      end
    end else if (tok_in) begin
      if (stall)         code = HS_STALL;
      else if (no_space) code = HS_NAK;
      else               code = HS_DATA;
    end else if (host_ack) begin
      flip = 1'b1;
    end
  end
endmodule

// File: rtl/usb_ep_toggle.sv
module usb_ep_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic setup_i,
  input  logic rst_i,
  input  logic flip_i,
  output logic tgl_q
);
  logic tgl_d;
  logic tgl_en;

  always_comb begin
    tgl_en = setup_i | rst_i | flip_i;
    if (setup_i)    tgl_d = 1'b1;
    else if (rst_i) tgl_d = 1'b0;
    else            tgl_d = ~tgl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tgl_q <= 1'b0;
    else if (tgl_en) tgl_q <= tgl_d;
  end
endmodule

// File: rtl/usb_ep_hs_ctrl.sv
module usb_ep_hs_ctrl
  import usb_ep_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_stall_set,
  input  logic              sw_stall_clr,
  input  logic              sw_tgl_rst,
  input  logic              sw_nyet_dis_set,
  input  logic              sw_nyet_dis_clr,
  input  logic              hs_mode,
  input  logic              tok_setup,
  input  logic              tok_out,
  input  logic              tok_in,
  input  logic              host_ack,
  input  logic [BANK_W-1:0] free_banks,
  output logic              hs_valid,
  output logic [2:0]        hs_code,
  output logic              exp_toggle,
  output logic              stall_q,
  output logic              nyet_dis_q
);
  logic [CTRL_BITS-1:0] set_v, clr_v, bits;
  hs_code_t             code_d;
  logic                 any_tok;
  logic                 flip;
  logic                 valid_d;
  logic [2:0]           code_nx;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[BIT_STALL] = sw_stall_set;
    clr_v[BIT_STALL] = sw_stall_clr | tok_setup;
    set_v[BIT_NYDIS] = sw_nyet_dis_set;
    clr_v[BIT_NYDIS] = sw_nyet_dis_clr;
  end

  usb_ep_ctrl_bits #(.NBITS(CTRL_BITS)) u_bits (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .bits_q (bits)
  );

  assign stall_q    = bits[BIT_STALL];
  assign nyet_dis_q = bits[BIT_NYDIS];

  usb_ep_hs_sel #(.BANK_W(BANK_W)) u_sel (
    .stall      (stall_q),
    .nyet_dis   (nyet_dis_q),
    .hs_mode    (hs_mode),
    .free_banks (free_banks),
    .tok_setup  (tok_setup),
    .tok_out    (tok_out),
    .tok_in     (tok_in),
    .host_ack   (host_ack),
    .code       (code_d),
    .any_tok    (any_tok),
    .flip       (flip)
  );

  usb_ep_toggle u_tgl (
    .clk     (clk),
    .rst_n   (rst_n),
    .setup_i (tok_setup),
    .rst_i   (sw_tgl_rst),
    .flip_i  (flip),
    .tgl_q   (exp_toggle)
  );

  always_comb begin
    valid_d = any_tok;
    code_nx = code_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_valid <= 1'b0;
      hs_code  <= 3'd0;
    end else begin
      hs_valid <= valid_d;
      hs_code  <= code_nx;
    end
  end
endmodule

// File: rtl/usb_ep_hs_chk.sv
module usb_ep_hs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_stall_set,
  input logic       sw_stall_clr,
  input logic       sw_tgl_rst,
  input logic       sw_nyet_dis_set,
  input logic       hs_mode,
  input logic       tok_setup,
  input logic       tok_out,
  input logic       tok_in,
  input logic       hs_valid,
  input logic [2:0] hs_code,
  input logic       exp_toggle,
  input logic       stall_q,
  input logic       nyet_dis_q
);
  assert_stall_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_stall_set |=> stall_q);
  assert_stall_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stall_clr && !sw_stall_set) |=> !stall_q);
  assert_setup_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tok_setup |=> (hs_valid && hs_code == 3'd1 && exp_toggle));
  assert_setup_unstall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_setup && !sw_stall_set) |=> !stall_q);
  assert_stalled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tok_setup && (tok_out || tok_in) && stall_q) |=> (hs_code == 3'd3));
  assert_nydis_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_nyet_dis_set |=> nyet_dis_q);
  assert_fs_no_nyet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_mode) |=> (hs_code != 3'd4));
  assert_tgl_rst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_tgl_rst && !tok_setup) |=> !exp_toggle);
  assert_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tok_setup && !tok_out && !tok_in) |=> (!hs_valid && hs_code == 3'd0));
endmodule

bind usb_ep_hs_ctrl usb_ep_hs_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .sw_stall_set    (sw_stall_set),
  .sw_stall_clr    (sw_stall_clr),
  .sw_tgl_rst      (sw_tgl_rst),
  .sw_nyet_dis_set (sw_nyet_dis_set),
  .hs_mode         (hs_mode),
  .tok_setup       (tok_setup),
  .tok_out         (tok_out),
  .tok_in          (tok_in),
  .hs_valid        (hs_valid),
  .hs_code         (hs_code),
  .exp_toggle      (exp_toggle),
  .stall_q         (stall_q),
  .nyet_dis_q      (nyet_dis_q)
);

// File: tb/sim_usb_ep_hs_ctrl.sv
`timescale 1ns/1ps
module sim_usb_ep_hs_ctrl;
  localparam int BW = 2;
  logic clk = 1'b0;
  logic rst_n;
  logic s_set, s_clr, t_rst, n_set, n_clr, hsm, t_setup, t_out, t_in, h_ack;
  logic [BW-1:0] fb;
  logic hs_valid, exp_toggle, stall_q, nyet_dis_q;
  logic [2:0] hs_code;

  int n_chk = 0;
  int n_err = 0;
  logic m_stall, m_nd, m_tgl, m_valid;
  logic [2:0] m_code;

  always #4 clk = ~clk;

  usb_ep_hs_ctrl #(.BANK_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_stall_set(s_set), .sw_stall_clr(s_clr),
    .sw_tgl_rst(t_rst), .sw_nyet_dis_set(n_set), .sw_nyet_dis_clr(n_clr),
    .hs_mode(hsm), .tok_setup(t_setup), .tok_out(t_out), .tok_in(t_in),
    .host_ack(h_ack), .free_banks(fb), .hs_valid(hs_valid), .hs_code(hs_code),
    .exp_toggle(exp_toggle), .stall_q(stall_q), .nyet_dis_q(nyet_dis_q));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected handshake code from requirements R3..R9, R11
  function automatic logic [2:0] exp_code(input logic st, input logic nd);
    if (t_setup) return 3'd1;
    if (t_out) begin
      if (st) return 3'd3;
      if (fb == 0) return 3'd2;
      if (hsm && fb == 1 && !nd) return 3'd4;
      return 3'd1;
    end
    if (t_in) begin
      if (st) return 3'd3;
      if (fb == 0) return 3'd2;
      return 3'd5;
    end
    return 3'd0;
  endfunction

  function automatic string code_req(input logic [2:0] c);
    case (c)
      3'd3: return "R4";
      3'd2: return "R5";
      3'd4: return "R6";
      3'd5: return "R9";
      3'd1: return t_setup ? "R3" : (hsm ? "R7" : "R8");
      default: return "R11";
    endcase
  endfunction

  task automatic clear_in();
    {s_set, s_clr, t_rst, n_set, n_clr, t_setup, t_out, t_in, h_ack} = '0;
  endtask

  // inputs already driven; advance one edge, update model, compare
  task automatic step();
    logic flip;
    string rq;
    m_code  = exp_code(m_stall, m_nd);
    rq      = code_req(m_code);
    m_valid = t_setup | t_out | t_in;
    flip = (!t_setup && t_out && !m_stall && fb != 0) ||
           (!t_setup && !t_out && !t_in && h_ack);
    if (t_setup) m_tgl = 1'b1;
    else if (t_rst) m_tgl = 1'b0;
    else if (flip) m_tgl = ~m_tgl;
    if (s_set) m_stall = 1'b1;
    else if (s_clr || t_setup) m_stall = 1'b0;
    if (n_set) m_nd = 1'b1;
    else if (n_clr) m_nd = 1'b0;
    @(posedge clk); #1;
    chk(hs_valid == m_valid, "R11", hs_valid, m_valid);
    chk(hs_code == m_code, rq, hs_code, m_code);
    chk(exp_toggle == m_tgl, t_rst ? "R10" : "R9", exp_toggle, m_tgl);
    chk(stall_q == m_stall, "R2", stall_q, m_stall);
    chk(nyet_dis_q == m_nd, "R7", nyet_dis_q, m_nd);
    @(negedge clk);
    clear_in();
  endtask

  initial begin
    #150000;
    n_err++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    clear_in(); hsm = 1'b1; fb = 2'd2;
    rst_n = 1'b0;
    m_stall = 0; m_nd = 0; m_tgl = 0;
    repeat (3) @(negedge clk);
    chk({hs_valid, stall_q, nyet_dis_q, exp_toggle} == 4'b0, "R1",
        {hs_valid, stall_q, nyet_dis_q, exp_toggle}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({hs_valid, stall_q, nyet_dis_q, exp_toggle} == 4'b0, "R1",
        {hs_valid, stall_q, nyet_dis_q, exp_toggle}, 0);
    // directed: R2 collision, R4 stall, R3 setup releases stall
    s_set = 1; s_clr = 1; step();
    t_out = 1; step();
    t_in = 1; step();
    t_setup = 1; step();
    // R10 toggle reset, R9 IN data then host ack
    t_rst = 1; step();
    t_in = 1; step();
    h_ack = 1; step();
    // R5 NAK, R6 NYET, R7 suppress, R8 full speed
    fb = 0; t_out = 1; step();
    fb = 1; t_out = 1; step();
    n_set = 1; n_clr = 1; step();
    t_out = 1; step();
    n_clr = 1; step();
    hsm = 0; t_out = 1; step();
    // R3 setup with set strobe same cycle, R10 overridden by setup
    s_set = 1; t_setup = 1; t_rst = 1; step();
    s_clr = 1; step();
    // R11 host_ack alone gives no valid
    h_ack = 1; step();
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 16;
      s_set = ($urandom % 10) == 0; s_clr = ($urandom % 8) == 0;
      t_rst = ($urandom % 12) == 0;
      n_set = ($urandom % 10) == 0; n_clr = ($urandom % 10) == 0;
      hsm = $urandom % 2; fb = BW'($urandom % 4);
      t_setup = (r == 0); t_out = (r >= 1 && r <= 6);
      t_in = (r >= 5 && r <= 9); h_ack = (r >= 9 && r <= 11);
      step();
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule